// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit data pointers and an 8-bit select/control register for an 8051-class core. The instruction decoder drives one-cycle strobes for the pointer-using operations: step the pointer, load it from an immediate, read a code table, read external data, write external data, and jump indirectly. The block applies each strobe to whichever pointer the select bit names. Software reaches the pointer bytes and the control register through a byte-wide SFR port. That port carries a write strobe and a separate direct-increment strobe.

The block drives two outputs. The active pointer goes straight out as the external-memory address. The active pointer plus the unsigned accumulator, cut to the code-space width, goes out as the code address for table reads and indirect jumps. Each pointer has its own count-down bit. An auto-flip bit swaps the selection after every pointer-using operation except the indirect jump. The memories, the program counter and the decoder sit outside the block.

Top module: `dptr_dual_unit`

## Requirements
- R1: After reset, all four pointer bytes and the control register read as zero, so pointer 0 is active, both pointers count up and auto-flip is off.
- R2: SFR map: pointer 0 low/high at 0x82/0x83, pointer 1 low/high at 0x84/0x85, control at 0x86. Writes land in the addressed byte. Reads return the stored value, including control bits 1 to 4, which have no function. Any other address reads 0 and is not written.
- R3: Control bit 0 selects the active pointer (0 = pointer 0, 1 = pointer 1). `dptr_out` shows the active pointer, and operations change only the active pointer.
- R4: The step operation counts pointer 0 down when control bit 6 is 1, and pointer 1 down when control bit 7 is 1. Otherwise it counts up. The result wraps modulo 2^16.
- R5: A direct increment of address 0x86 inverts control bit 0 only. A direct increment of a pointer byte adds one to that byte modulo 256, with no carry into the other byte.
- R6: While control bit 5 is 1, control bit 0 inverts after each step, immediate load, code-table read, external read and external write.
- R7: The indirect jump never changes the control register, even with bit 5 set.
- R8: The immediate load places `imm_hi` in the active pointer's high byte and `imm_lo` in its low byte.
- R9: `code_addr` equals (active pointer + zero-extended `acc`) modulo 2^CODE_AW.
- R10: Code-table reads, external reads and writes, and indirect jumps leave both pointer values unchanged.
- R11: At most one operation strobe is high per cycle. When any strobe is high, an SFR write or direct increment in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for read, write and direct increment |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_inc | input | 1 | Direct-address increment strobe |
| sfr_rdata | output | 8 | Combinational SFR read data |
| op_inc | input | 1 | Step active pointer |
| op_load | input | 1 | Load active pointer from immediate |
| op_code_rd | input | 1 | Code-table read through pointer |
| op_ext_rd | input | 1 | External read through pointer |
| op_ext_wr | input | 1 | External write through pointer |
| op_jmp | input | 1 | Indirect jump through pointer |
| acc | input | 8 | Accumulator value |
| imm_hi | input | 8 | First immediate byte (high) |
| imm_lo | input | 8 | Second immediate byte (low) |
| dptr_out | output | 16 | Active pointer (external address) |
| code_addr | output | CODE_AW | Active pointer plus accumulator, masked |

## Verification
The bench drives each pointer through its own count-down bit. A design that used the wrong bit, or a shared bit, counts the alternate pointer the wrong way, and the bench also wraps both pointers across 0000/FFFF. It applies a direct increment to the control register when bits 1 to 7 are set. A plain adder there would carry into bit 1 and corrupt the stored bits. It runs every pointer-using operation with auto-flip on, including the indirect jump, so a missing or extra flip shows up as the wrong pointer on `dptr_out`. It also collides SFR writes with operation strobes, and uses a 12-bit code space, so an unmasked sum or a byte update that wins the collision is caught.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 2 * BYTE_W;
  localparam int NUM_PTR = 2;

  localparam logic [BYTE_W-1:0] SFR_P0_LO = 8'h82;
  localparam logic [BYTE_W-1:0] SFR_P0_HI = 8'h83;
  localparam logic [BYTE_W-1:0] SFR_P1_LO = 8'h84;
  localparam logic [BYTE_W-1:0] SFR_P1_HI = 8'h85;
  localparam logic [BYTE_W-1:0] SFR_CTL   = 8'h86;

  localparam int CB_SEL   = 0;
  localparam int CB_AUTO  = 5;
  localparam int CB_DOWN0 = 6;

  typedef enum logic [2:0] {
    OP_NONE, OP_STEP, OP_LOAD, OP_CODE, OP_XRD, OP_XWR, OP_JMP
  } op_e;

  function automatic logic [BYTE_W-1:0] f_lo_addr(input int idx);
    return (idx == 0) ? SFR_P0_LO : SFR_P1_LO;
  endfunction

  function automatic logic [BYTE_W-1:0] f_hi_addr(input int idx);
    return (idx == 0) ? SFR_P0_HI : SFR_P1_HI;
  endfunction

  function automatic logic [PTR_W-1:0] f_step(input logic [PTR_W-1:0] p,
                                              input logic down);
    return down ? (p - PTR_W'(1)) : (p + PTR_W'(1));
  endfunction

  function automatic logic [PTR_W-1:0] f_offset(input logic [PTR_W-1:0] p,
                                                input logic [BYTE_W-1:0] a);
    return p + {{(PTR_W-BYTE_W){1'b0}}, a};
  endfunction

  function automatic logic f_moves_sel(input op_e op);
    return (op == OP_STEP) || (op == OP_LOAD) || (op == OP_CODE) ||
           (op == OP_XRD)  || (op == OP_XWR);
  endfunction
endpackage

// File: rtl/dptr_op_decode.sv
module dptr_op_decode
  import dptr_pkg::*;
(
  input  logic              op_inc,
  input  logic              op_load,
  input  logic              op_code_rd,
  input  logic              op_ext_rd,
  input  logic              op_ext_wr,
  input  logic              op_jmp,
  input  logic              sfr_wr,
  input  logic              sfr_inc,
  input  logic [BYTE_W-1:0] sfr_addr,
  output op_e               op,
  output logic              op_any,
  output logic [NUM_PTR-1:0] wr_lo,
  output logic [NUM_PTR-1:0] wr_hi,
  output logic [NUM_PTR-1:0] inc_lo,
  output logic [NUM_PTR-1:0] inc_hi,
  output logic              wr_ctl,
  output logic              inc_ctl
);
  always_comb begin
    if (op_inc)          op = OP_STEP;
    else if (op_load)    op = OP_LOAD;
    else if (op_code_rd) op = OP_CODE;
    else if (op_ext_rd)  op = OP_XRD;
    else if (op_ext_wr)  op = OP_XWR;
    else if (op_jmp)     op = OP_JMP;
    else                 op = OP_NONE;
  end

  assign op_any = (op != OP_NONE);

  // SFR side only acts in cycles without an operation strobe
  logic sfr_wr_ok, sfr_inc_ok;
  assign sfr_wr_ok  = sfr_wr  && !op_any;
  assign sfr_inc_ok = sfr_inc && !op_any;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr_dec
    logic hit_lo, hit_hi;
    assign hit_lo    = (sfr_addr == f_lo_addr(g));
    assign hit_hi    = (sfr_addr == f_hi_addr(g));
    assign wr_lo[g]  = sfr_wr_ok  && hit_lo;
    assign wr_hi[g]  = sfr_wr_ok  && hit_hi;
    assign inc_lo[g] = sfr_inc_ok && hit_lo;
    assign inc_hi[g] = sfr_inc_ok && hit_hi;
  end

  assign wr_ctl  = sfr_wr_ok  && (sfr_addr == SFR_CTL);
  assign inc_ctl = sfr_inc_ok && (sfr_addr == SFR_CTL);
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
  import dptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              down,
  input  op_e               op,
  input  logic [PTR_W-1:0]  imm,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              inc_lo,
  input  logic              inc_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);
  logic step_fire, load_fire, sfr_touch, hold_op;
  logic [PTR_W-1:0] ptr_nxt;

  assign step_fire = active && (op == OP_STEP);
  assign load_fire = active && (op == OP_LOAD);
  assign sfr_touch = wr_lo || wr_hi || inc_lo || inc_hi;
  assign hold_op   = (op == OP_CODE) || (op == OP_XRD) ||
                     (op == OP_XWR)  || (op == OP_JMP);

  always_comb begin
    ptr_nxt = ptr;
    if (step_fire) begin
      ptr_nxt = f_step(ptr, down);
    end else if (load_fire) begin
      ptr_nxt = imm;
    end else begin
      if (wr_lo)  ptr_nxt[BYTE_W-1:0]     = wdata;
      if (wr_hi)  ptr_nxt[PTR_W-1:BYTE_W] = wdata;
      if (inc_lo) ptr_nxt[BYTE_W-1:0]     = ptr[BYTE_W-1:0] + BYTE_W'(1);
      if (inc_hi) ptr_nxt[PTR_W-1:BYTE_W] = ptr[PTR_W-1:BYTE_W] + BYTE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !down) |=> (ptr == $past(ptr) + PTR_W'(1))) else $error("step up"); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && down) |=> (ptr == $past(ptr) - PTR_W'(1))) else $error("step down"); // R4
  AST_LOAD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (ptr == $past(imm))) else $error("load"); // R8
  AST_IDLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sfr_touch) |=> $stable(ptr)) else $error("inactive moved"); // R3
  AST_HOLD_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_op |=> $stable(ptr)) else $error("hold op moved ptr"); // R10
endmodule

// File: rtl/dptr_ctl.sv
module dptr_ctl
  import dptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              wr_ctl,
  input  logic              inc_ctl,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctl
);
  logic flip_fire;
  logic [BYTE_W-1:0] ctl_nxt;

  assign flip_fire = ctl[CB_AUTO] && f_moves_sel(op);

  always_comb begin
    ctl_nxt = ctl;
    if (flip_fire)    ctl_nxt[CB_SEL] = ~ctl[CB_SEL];
    else if (wr_ctl)  ctl_nxt = wdata;
    else if (inc_ctl) ctl_nxt[CB_SEL] = ~ctl[CB_SEL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_nxt;
  end

  AST_AUTO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    flip_fire |=> (ctl[CB_SEL] != $past(ctl[CB_SEL]))) else $error("no flip"); // R6
  AST_JMP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JMP) |=> $stable(ctl)) else $error("jmp changed ctl"); // R7
  AST_DIRECT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ctl |=> ((ctl[BYTE_W-1:1] == $past(ctl[BYTE_W-1:1])) &&
                 (ctl[CB_SEL] != $past(ctl[CB_SEL])))) else $error("direct inc"); // R5
endmodule

// File: rtl/dptr_addr_gen.sv
module dptr_addr_gen
  import dptr_pkg::*;
#(
  parameter int CODE_AW = 16
)(
  input  logic [PTR_W-1:0]   ptr,
  input  logic [BYTE_W-1:0]  acc,
  output logic [CODE_AW-1:0] code_addr
);
  logic [PTR_W-1:0] sum_full;
  assign sum_full  = f_offset(ptr, acc);
  assign code_addr = sum_full[CODE_AW-1:0];
endmodule

// File: rtl/dptr_dual_unit.sv
module dptr_dual_unit
  import dptr_pkg::*;
#(
  parameter int CODE_AW = 16
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         sfr_addr,
  input  logic               sfr_wr,
  input  logic [7:0]         sfr_wdata,
  input  logic               sfr_inc,
  output logic [7:0]         sfr_rdata,
  input  logic               op_inc,
  input  logic               op_load,
  input  logic               op_code_rd,
  input  logic               op_ext_rd,
  input  logic               op_ext_wr,
  input  logic               op_jmp,
  input  logic [7:0]         acc,
  input  logic [7:0]         imm_hi,
  input  logic [7:0]         imm_lo,
  output logic [15:0]        dptr_out,
  output logic [CODE_AW-1:0] code_addr
);
  op_e op;
  logic op_any, wr_ctl, inc_ctl;
  logic [NUM_PTR-1:0] wr_lo, wr_hi, inc_lo, inc_hi;
  logic [BYTE_W-1:0] ctl_q;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs;
  logic [PTR_W-1:0] active_ptr;

  dptr_op_decode u_dec (
    .op_inc(op_inc), .op_load(op_load), .op_code_rd(op_code_rd),
    .op_ext_rd(op_ext_rd), .op_ext_wr(op_ext_wr), .op_jmp(op_jmp),
    .sfr_wr(sfr_wr), .sfr_inc(sfr_inc), .sfr_addr(sfr_addr),
    .op(op), .op_any(op_any),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .inc_lo(inc_lo), .inc_hi(inc_hi),
    .wr_ctl(wr_ctl), .inc_ctl(inc_ctl)
  );

  dptr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .op(op), .wr_ctl(wr_ctl), .inc_ctl(inc_ctl),
    .wdata(sfr_wdata), .ctl(ctl_q)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_bank
    dptr_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .active(ctl_q[CB_SEL] == g[0]),
      .down(ctl_q[CB_DOWN0+g]),
      .op(op), .imm({imm_hi, imm_lo}),
      .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]),
      .inc_lo(inc_lo[g]), .inc_hi(inc_hi[g]),
      .wdata(sfr_wdata), .ptr(ptrs[g])
    );
  end

  assign active_ptr = ptrs[ctl_q[CB_SEL]];
  assign dptr_out   = active_ptr;

  dptr_addr_gen #(.CODE_AW(CODE_AW)) u_agen (
    .ptr(active_ptr), .acc(acc), .code_addr(code_addr)
  );

  always_comb begin
    case (sfr_addr)
      SFR_P0_LO: sfr_rdata = ptrs[0][BYTE_W-1:0];
      SFR_P0_HI: sfr_rdata = ptrs[0][PTR_W-1:BYTE_W];
      SFR_P1_LO: sfr_rdata = ptrs[1][BYTE_W-1:0];
      SFR_P1_HI: sfr_rdata = ptrs[1][PTR_W-1:BYTE_W];
      SFR_CTL:   sfr_rdata = ctl_q;
      default:   sfr_rdata = '0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_inc, op_load, op_code_rd, op_ext_rd, op_ext_wr, op_jmp}))
    else $error("multiple strobes"); // R11
  AST_OP_BEATS_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_jmp && (sfr_wr || sfr_inc)) |=> ($stable(ctl_q) && $stable(ptrs)))
    else $error("sfr beat op"); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> ((ctl_q == '0) && (ptrs == '0))) else $error("reset"); // R1
endmodule

// File: tb/tb_dptr_dual_unit.sv
module tb_dptr_dual_unit;
  localparam int CAW = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata, acc, imm_hi, imm_lo;
  logic sfr_wr, sfr_inc;
  logic op_inc, op_load, op_code_rd, op_ext_rd, op_ext_wr, op_jmp;
  logic [15:0] dptr_out;
  logic [CAW-1:0] code_addr;

  dptr_dual_unit #(.CODE_AW(CAW)) dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_inc(sfr_inc), .sfr_rdata(sfr_rdata),
    .op_inc(op_inc), .op_load(op_load), .op_code_rd(op_code_rd),
    .op_ext_rd(op_ext_rd), .op_ext_wr(op_ext_wr), .op_jmp(op_jmp),
    .acc(acc), .imm_hi(imm_hi), .imm_lo(imm_lo),
    .dptr_out(dptr_out), .code_addr(code_addr)
  );

  typedef struct {
    string       req;
    string       what;
    int          kind;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_p0, m_p1;
  logic [7:0]  m_ctl;

  // ops bits: [0] step [1] load [2] code read [3] ext read [4] ext write [5] jump
  localparam logic [5:0] K_STEP = 6'b000001, K_LOAD = 6'b000010, K_CODE = 6'b000100,
                         K_XRD  = 6'b001000, K_XWR  = 6'b010000, K_JMP  = 6'b100000;

  function automatic logic [15:0] m_active();
    if (m_ctl[0]) return m_p1;
    return m_p0;
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'h82) return m_p0[7:0];
    if (a == 8'h83) return m_p0[15:8];
    if (a == 8'h84) return m_p1[7:0];
    if (a == 8'h85) return m_p1[15:8];
    if (a == 8'h86) return m_ctl;
    return 8'h00;
  endfunction

  // monitor: compares queued expectations after the edge settles
  always @(posedge clk) begin
    #5;
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      if (it.kind == 0)      act = dptr_out;
      else if (it.kind == 1) act = {{(16-CAW){1'b0}}, code_addr};
      else                   act = {8'h00, sfr_rdata};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s actual=%h expected=%h", it.req, it.what, act, it.exp);
      end
    end
  end

  task automatic set_idle();
    sfr_wr = 1'b0; sfr_inc = 1'b0; sfr_wdata = 8'h00;
    {op_jmp, op_ext_wr, op_ext_rd, op_code_rd, op_load, op_inc} = 6'b0;
    imm_hi = 8'h00; imm_lo = 8'h00;
  endtask

  task automatic drive(input logic [5:0] ops, input logic wr, input logic inc,
                       input logic [7:0] a, input logic [7:0] wd,
                       input logic [7:0] ac, input logic [15:0] imm);
    logic [15:0] cur;
    logic        s;
    @(negedge clk);
    {op_jmp, op_ext_wr, op_ext_rd, op_code_rd, op_load, op_inc} = ops;
    sfr_wr = wr; sfr_inc = inc; sfr_addr = a; sfr_wdata = wd;
    acc = ac; imm_hi = imm[15:8]; imm_lo = imm[7:0];
    @(posedge clk);
    s = m_ctl[0];
    cur = s ? m_p1 : m_p0;
    if (ops != 6'b0) begin
      if (ops[0]) begin
        if ((s && m_ctl[7]) || (!s && m_ctl[6])) cur = cur - 16'd1;
        else cur = cur + 16'd1;
      end
      if (ops[1]) cur = imm;
      if (s) m_p1 = cur; else m_p0 = cur;
      if (m_ctl[5] && (ops[4:0] != 5'b0)) m_ctl[0] = ~m_ctl[0];
    end else begin
      if (wr) begin
        case (a)
          8'h82: m_p0[7:0] = wd;
          8'h83: m_p0[15:8] = wd;
          8'h84: m_p1[7:0] = wd;
          8'h85: m_p1[15:8] = wd;
          8'h86: m_ctl = wd;
          default: ;
        endcase
      end
      if (inc) begin
        case (a)
          8'h82: m_p0[7:0] = m_p0[7:0] + 8'd1;
          8'h83: m_p0[15:8] = m_p0[15:8] + 8'd1;
          8'h84: m_p1[7:0] = m_p1[7:0] + 8'd1;
          8'h85: m_p1[15:8] = m_p1[15:8] + 8'd1;
          8'h86: m_ctl[0] = ~m_ctl[0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic wr_sfr(input logic [7:0] a, input logic [7:0] d);
    drive(6'b0, 1'b1, 1'b0, a, d, 8'h00, 16'h0);
  endtask

  task automatic do_op(input logic [5:0] ops, input logic [15:0] imm);
    drive(ops, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, imm);
  endtask

  // one idle cycle with three expectations queued for the monitor
  task automatic chk(input string req, input logic [7:0] a, input logic [7:0] ac);
    logic [15:0] ap;
    @(negedge clk);
    set_idle();
    sfr_addr = a; acc = ac;
    ap = m_active();
    q.push_back('{req: req, what: "dptr_out",  kind: 0, exp: ap});
    q.push_back('{req: req, what: "code_addr", kind: 1,
                  exp: (ap + {8'h00, ac}) & 16'((1 << CAW) - 1)});
    q.push_back('{req: req, what: "sfr_rdata", kind: 2, exp: {8'h00, m_read(a)}});
    @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    set_idle();
    sfr_addr = 8'h00; acc = 8'h00;
    m_p0 = 16'h0; m_p1 = 16'h0; m_ctl = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", 8'h86, 8'h00);
    chk("R1", 8'h84, 8'h00);

    // R2 map and readback incl. spare control bits
    wr_sfr(8'h82, 8'h34); wr_sfr(8'h83, 8'h12);
    wr_sfr(8'h84, 8'hCD); wr_sfr(8'h85, 8'hAB);
    wr_sfr(8'h86, 8'h1E);
    chk("R2", 8'h82, 8'h00); chk("R2", 8'h83, 8'h00);
    chk("R2", 8'h84, 8'h00); chk("R2", 8'h85, 8'h00);
    chk("R2", 8'h86, 8'h00);
    wr_sfr(8'h80, 8'h77);
    chk("R2", 8'h80, 8'h00);

    // R3 selection: step only the alternate pointer
    wr_sfr(8'h86, 8'h1F);
    chk("R3", 8'h86, 8'h00);
    do_op(K_STEP, 16'h0);
    chk("R3", 8'h82, 8'h00);
    chk("R3", 8'h84, 8'h00);

    // R4 per-pointer direction
    wr_sfr(8'h86, 8'h81);
    do_op(K_STEP, 16'h0);
    chk("R4", 8'h84, 8'h00);
    wr_sfr(8'h86, 8'h41);
    do_op(K_STEP, 16'h0);
    chk("R4", 8'h85, 8'h00);
    do_op(K_LOAD, 16'hFFFF);
    do_op(K_STEP, 16'h0);
    chk("R4", 8'h84, 8'h00);
    wr_sfr(8'h86, 8'h40);
    wr_sfr(8'h82, 8'h00); wr_sfr(8'h83, 8'h00);
    do_op(K_STEP, 16'h0);
    chk("R4", 8'h83, 8'h00);

    // R8 immediate load byte order
    wr_sfr(8'h86, 8'h01);
    do_op(K_LOAD, 16'h5AC3);
    chk("R8", 8'h85, 8'h00);
    chk("R8", 8'h84, 8'h00);

    // R5 direct increment
    wr_sfr(8'h86, 8'hFE);
    drive(6'b0, 1'b0, 1'b1, 8'h86, 8'h00, 8'h00, 16'h0);
    chk("R5", 8'h86, 8'h00);
    drive(6'b0, 1'b0, 1'b1, 8'h86, 8'h00, 8'h00, 16'h0);
    chk("R5", 8'h86, 8'h00);
    wr_sfr(8'h82, 8'hFF); wr_sfr(8'h83, 8'hFF);
    drive(6'b0, 1'b0, 1'b1, 8'h82, 8'h00, 8'h00, 16'h0);
    chk("R5", 8'h83, 8'h00);
    chk("R5", 8'h82, 8'h00);

    // R6 auto-flip after each pointer-using op
    wr_sfr(8'h86, 8'h20);
    do_op(K_STEP, 16'h0); chk("R6", 8'h86, 8'h00);
    do_op(K_LOAD, 16'h0FF0); chk("R6", 8'h86, 8'h00);
    do_op(K_CODE, 16'h0); chk("R6", 8'h86, 8'h00);
    do_op(K_XRD, 16'h0); chk("R6", 8'h86, 8'h00);
    do_op(K_XWR, 16'h0); chk("R6", 8'h86, 8'h00);

    // R7 indirect jump never flips
    do_op(K_JMP, 16'h0); chk("R7", 8'h86, 8'h00);
    do_op(K_JMP, 16'h0); chk("R7", 8'h86, 8'h00);

    // R9 code address with masking
    wr_sfr(8'h86, 8'h00);
    wr_sfr(8'h82, 8'hF0); wr_sfr(8'h83, 8'h0F);
    chk("R9", 8'h82, 8'h20);
    chk("R9", 8'h82, 8'hFF);
    wr_sfr(8'h83, 8'hFF);
    chk("R9", 8'h83, 8'h10);

    // R10 non-moving operations keep both pointers
    do_op(K_XRD, 16'h0); chk("R10", 8'h82, 8'h00);
    do_op(K_XWR, 16'h0); chk("R10", 8'h83, 8'h00);
    do_op(K_CODE, 16'h0); chk("R10", 8'h84, 8'h05);
    do_op(K_JMP, 16'h0); chk("R10", 8'h85, 8'h00);

    // R11 operation beats a same-cycle SFR access
    drive(K_STEP, 1'b1, 1'b0, 8'h82, 8'h55, 8'h00, 16'h0);
    chk("R11", 8'h82, 8'h00);
    drive(K_XRD, 1'b1, 1'b0, 8'h86, 8'h01, 8'h00, 16'h0);
    chk("R11", 8'h86, 8'h00);
    drive(K_JMP, 1'b0, 1'b1, 8'h86, 8'h00, 8'h00, 16'h0);
    chk("R11", 8'h86, 8'h00);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule